// File: doc/BRIEF.md
# Pushbuffer Method Stream Decoder

This block takes a stream of 32-bit command words on a valid/ready input and turns it into method writes. A header word either opens a burst of data words or carries its own small data value. Each data word then leaves as one write that carries a method byte offset, the data, a subchannel and a last flag. The method address decides where the write goes. Low methods go to a local class register port. Mid-range methods go to one of several engine ports, picked by subchannel. High methods go to a macro unit interface, and only on two subchannels.

The macro interface carries three operations: start, push-argument and execute. When the last word of a macro burst has been taken, the block issues one extra execute operation for the same macro index. The input is held off until that execute has been accepted. Every output port uses valid/ready handshaking, and the input stalls while the chosen destination is not ready. Words that go to no destination are taken at once and produce no output.

Top module: `pb_method_decoder`

## Requirements
- R1: The opcode is in header bits 31:29. Value 1 opens an incrementing burst, 3 a non-incrementing burst, 5 an increment-once burst and 4 an immediate write. Values 0, 2, 6 and 7 are taken with in_ready high and produce no output.
- R2: The method is in header bits 11:0, the subchannel in bits 15:13 and the burst count in bits 28:16. For an immediate, bits 28:16 are the data, zero-extended to 32 bits.
- R3: In an incrementing burst of method M, data word k (counting from 0) is written to method M+k.
- R4: In a non-incrementing burst, every data word is written to the header's method.
- R5: In an increment-once burst, the first data word goes to method M and every later word goes to M+1.
- R6: A method below 0x60 goes to the local port (loc_*) with byte offset method*4, whatever the subchannel.
- R7: A method from 0x60 to 0xDFF goes to engine port eng_valid[s] for subchannel s in 0 to 4, with byte offset method*4. On subchannels 5 to 7 the word is taken and dropped.
- R8: A method of 0xE00 or above goes to the macro port on subchannel 0 or 3 only, with index (method>>1)&0x7F. An odd method has mac_op 1 (push) and an even method has mac_op 0 (start). On any other subchannel the word is taken and dropped.
- R9: The last flag is 1 when the remaining burst count is 1, and it is always 1 for an immediate.
- R10: In the cycle after a macro start or push with last set is accepted, the macro port shows mac_op 2 (execute) with the same index, data 0 and last 1. in_ready stays low until that execute is accepted.
- R11: A burst header with a count of zero opens no burst, so the next word is decoded as a header.
- R12: While the selected destination is not ready, in_ready is low and the offered write stays stable.
- R13: Reset clears any open burst and any pending execute. After reset no output is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Command word valid |
| in_ready | output | 1 | Command word taken |
| in_word | input | 32 | Command word |
| loc_valid | output | 1 | Local register write valid |
| loc_ready | input | 1 | Local port ready |
| loc_offset | output | 14 | Local byte offset |
| loc_data | output | 32 | Local write data |
| loc_last | output | 1 | Local last flag |
| eng_valid | output | 5 | Per-engine write valid |
| eng_ready | input | 5 | Per-engine ready |
| eng_offset | output | 14 | Engine byte offset |
| eng_data | output | 32 | Engine write data |
| eng_last | output | 1 | Engine last flag |
| mac_valid | output | 1 | Macro operation valid |
| mac_ready | input | 1 | Macro unit ready |
| mac_op | output | 2 | 0 start, 1 push, 2 execute |
| mac_index | output | 7 | Macro index |
| mac_data | output | 32 | Macro argument |
| mac_last | output | 1 | Macro last flag |

## Verification
Two actions can meet in one cycle: a pending execute for a macro, and the next command word already on the input. The bench provokes this by keeping in_valid high with a local immediate right behind a macro start that carries the last flag. It also holds mac_ready low during the execute. It then checks that the execute comes first with the right index and that in_ready stays low throughout. The queued word must reach the local port only in the cycle after the execute has been accepted.

// File: rtl/pbd_pkg.sv
package pbd_pkg;

    localparam int WORD_W  = 32;
    localparam int METH_W  = 12;
    localparam int SUB_W   = 3;
    localparam int CNT_W   = 13;
    localparam int OFF_W   = METH_W + 2;
    localparam int MIDX_W  = 7;

    typedef enum logic [2:0] {
        OPC_INC  = 3'd1,
        OPC_NINC = 3'd3,
        OPC_IMM  = 3'd4,
        OPC_ONCE = 3'd5
    } opcode_e;

    typedef enum logic [1:0] {
        BM_INC  = 2'd0,
        BM_NINC = 2'd1,
        BM_ONCE = 2'd2
    } burst_mode_e;

    typedef enum logic [1:0] {
        MOP_START = 2'd0,
        MOP_PUSH  = 2'd1,
        MOP_EXEC  = 2'd2
    } mac_op_e;

    typedef struct packed {
        logic [METH_W-1:0] method;
        logic [SUB_W-1:0]  subch;
        logic [WORD_W-1:0] data;
        logic              last;
    } meth_req_t;

    function automatic logic is_burst_op(input logic [2:0] op);
        return (op == OPC_INC) || (op == OPC_NINC) || (op == OPC_ONCE);
    endfunction

    function automatic burst_mode_e mode_of(input logic [2:0] op);
        case (op)
            OPC_NINC: return BM_NINC;
            OPC_ONCE: return BM_ONCE;
            default:  return BM_INC;
        endcase
    endfunction

endpackage

// File: rtl/pbd_burst_ctrl.sv
module pbd_burst_ctrl
    import pbd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] word,
    input  logic              take,
    output logic              is_data,
    output meth_req_t         req
);
    logic [CNT_W-1:0]  cnt_q;
    logic [METH_W-1:0] meth_q;
    logic [SUB_W-1:0]  sub_q;
    burst_mode_e       mode_q;

    logic              in_burst;
    logic [2:0]        op;
    logic [CNT_W-1:0]  hdr_cnt;

    assign in_burst = (cnt_q != '0);
    assign op       = word[31:29];
    assign hdr_cnt  = word[28:16];

    always_comb begin
        req     = '0;
        is_data = 1'b0;
        if (in_burst) begin
            is_data    = 1'b1;
            req.method = meth_q;
            req.subch  = sub_q;
            req.data   = word;
            req.last   = (cnt_q == CNT_W'(1));
        end else if (op == OPC_IMM) begin
            is_data    = 1'b1;
            req.method = word[METH_W-1:0];
            req.subch  = word[15:13];
            req.data   = WORD_W'(hdr_cnt);
            req.last   = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            meth_q <= '0;
            sub_q  <= '0;
            mode_q <= BM_INC;
        end else if (take) begin
            if (in_burst) begin
                cnt_q <= cnt_q - 1'b1;
                case (mode_q)
                    BM_INC:  meth_q <= meth_q + 1'b1;
                    BM_ONCE: begin
                        meth_q <= meth_q + 1'b1;
                        mode_q <= BM_NINC;
                    end
                    default: meth_q <= meth_q;
                endcase
            end else if (is_burst_op(op)) begin
                cnt_q  <= hdr_cnt;
                meth_q <= word[METH_W-1:0];
                sub_q  <= word[15:13];
                mode_q <= mode_of(op);
            end
        end
    end
endmodule

// File: rtl/pbd_router.sv
module pbd_router
    import pbd_pkg::*;
#(
    parameter int N_ENG       = 5,
    parameter int LOCAL_END   = 'h60,
    parameter int MACRO_BASE  = 'hE00,
    parameter int MAC_SUB_A   = 0,
    parameter int MAC_SUB_B   = 3
) (
    input  logic             req_valid,
    input  meth_req_t        req,
    input  logic             loc_ready,
    input  logic [N_ENG-1:0] eng_ready,
    input  logic             mac_ready,
    output logic             loc_v,
    output logic [N_ENG-1:0] eng_v,
    output logic             mac_v,
    output logic             route_ready
);
    logic is_loc, is_mac, is_eng, mac_ok;

    assign is_loc = (int'(req.method) < LOCAL_END);
    assign is_mac = (int'(req.method) >= MACRO_BASE);
    assign is_eng = !is_loc && !is_mac;
    assign mac_ok = (req.subch == SUB_W'(MAC_SUB_A)) || (req.subch == SUB_W'(MAC_SUB_B));

    assign loc_v = req_valid && is_loc;
    assign mac_v = req_valid && is_mac && mac_ok;

    for (genvar g = 0; g < N_ENG; g++) begin : g_eng
        assign eng_v[g] = req_valid && is_eng && (req.subch == SUB_W'(g));
    end

    always_comb begin
        if (loc_v)           route_ready = loc_ready;
        else if (|eng_v)     route_ready = |(eng_v & eng_ready);
        else if (mac_v)      route_ready = mac_ready;
        else                 route_ready = 1'b1;
    end
endmodule

// File: rtl/pbd_macro_seq.sv
module pbd_macro_seq
    import pbd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              last_take,
    input  logic [MIDX_W-1:0] idx_in,
    input  logic              mac_ready,
    output logic              exec_pend,
    output logic [MIDX_W-1:0] exec_idx
);
    always_ff @(posedge clk) begin
        if (rst) begin
            exec_pend <= 1'b0;
            exec_idx  <= '0;
        end else if (exec_pend) begin
            if (mac_ready) exec_pend <= 1'b0;
        end else if (last_take) begin
            exec_pend <= 1'b1;
            exec_idx  <= idx_in;
        end
    end
endmodule

// File: rtl/pb_method_decoder.sv
module pb_method_decoder
    import pbd_pkg::*;
#(
    parameter int N_ENG      = 5,
    parameter int LOCAL_END  = 'h60,
    parameter int MACRO_BASE = 'hE00,
    parameter int MAC_SUB_A  = 0,
    parameter int MAC_SUB_B  = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [WORD_W-1:0] in_word,
    output logic              loc_valid,
    input  logic              loc_ready,
    output logic [OFF_W-1:0]  loc_offset,
    output logic [WORD_W-1:0] loc_data,
    output logic              loc_last,
    output logic [N_ENG-1:0]  eng_valid,
    input  logic [N_ENG-1:0]  eng_ready,
    output logic [OFF_W-1:0]  eng_offset,
    output logic [WORD_W-1:0] eng_data,
    output logic              eng_last,
    output logic              mac_valid,
    input  logic              mac_ready,
    output logic [1:0]        mac_op,
    output logic [MIDX_W-1:0] mac_index,
    output logic [WORD_W-1:0] mac_data,
    output logic              mac_last
);
    meth_req_t         req;
    logic              is_data, take, route_ready, req_valid;
    logic              loc_v, mac_v, exec_pend;
    logic [N_ENG-1:0]  eng_v;
    logic [MIDX_W-1:0] exec_idx, req_idx;

    assign req_valid = in_valid && is_data && !exec_pend;
    assign in_ready  = !exec_pend && (!is_data || route_ready);
    assign take      = in_valid && in_ready;
    assign req_idx   = req.method[MIDX_W:1];

    pbd_burst_ctrl u_burst (
        .clk     (clk),
        .rst     (rst),
        .word    (in_word),
        .take    (take),
        .is_data (is_data),
        .req     (req)
    );

    pbd_router #(
        .N_ENG      (N_ENG),
        .LOCAL_END  (LOCAL_END),
        .MACRO_BASE (MACRO_BASE),
        .MAC_SUB_A  (MAC_SUB_A),
        .MAC_SUB_B  (MAC_SUB_B)
    ) u_route (
        .req_valid   (req_valid),
        .req         (req),
        .loc_ready   (loc_ready),
        .eng_ready   (eng_ready),
        .mac_ready   (mac_ready),
        .loc_v       (loc_v),
        .eng_v       (eng_v),
        .mac_v       (mac_v),
        .route_ready (route_ready)
    );

    pbd_macro_seq u_mseq (
        .clk       (clk),
        .rst       (rst),
        .last_take (mac_v && mac_ready && req.last),
        .idx_in    (req_idx),
        .mac_ready (mac_ready),
        .exec_pend (exec_pend),
        .exec_idx  (exec_idx)
    );

    assign loc_valid  = loc_v;
    assign loc_offset = {req.method, 2'b00};
    assign loc_data   = req.data;
    assign loc_last   = req.last;

    assign eng_valid  = eng_v;
    assign eng_offset = {req.method, 2'b00};
    assign eng_data   = req.data;
    assign eng_last   = req.last;

    always_comb begin
        if (exec_pend) begin
            mac_valid = 1'b1;
            mac_op    = MOP_EXEC;
            mac_index = exec_idx;
            mac_data  = '0;
            mac_last  = 1'b1;
        end else begin
            mac_valid = mac_v;
            mac_op    = req.method[0] ? MOP_PUSH : MOP_START;
            mac_index = req_idx;
            mac_data  = req.data;
            mac_last  = req.last;
        end
    end
endmodule

// File: rtl/pbd_decoder_chk.sv
module pbd_decoder_chk
    import pbd_pkg::*;
#(
    parameter int N_ENG = 5
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic              in_ready,
    input logic              loc_valid,
    input logic              loc_ready,
    input logic [OFF_W-1:0]  loc_offset,
    input logic [WORD_W-1:0] loc_data,
    input logic [N_ENG-1:0]  eng_valid,
    input logic [N_ENG-1:0]  eng_ready,
    input logic [OFF_W-1:0]  eng_offset,
    input logic              mac_valid,
    input logic              mac_ready,
    input logic [1:0]        mac_op,
    input logic [MIDX_W-1:0] mac_index,
    input logic              mac_last
);
    // R6
    local_range_chk: assert property (@(posedge clk) disable iff (rst)
        loc_valid |-> (loc_offset < OFF_W'('h180)));

    // R7
    engine_range_chk: assert property (@(posedge clk) disable iff (rst)
        (eng_valid != '0) |-> (eng_offset >= OFF_W'('h180)) && (eng_offset < OFF_W'('h3800)));

    // R7
    one_dest_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({loc_valid, eng_valid, mac_valid}));

    // R10
    exec_follow_chk: assert property (@(posedge clk) disable iff (rst)
        (mac_valid && mac_ready && mac_op != MOP_EXEC && mac_last)
        |=> (mac_valid && mac_op == MOP_EXEC && mac_index == $past(mac_index)));

    // R10
    exec_stall_chk: assert property (@(posedge clk) disable iff (rst)
        (mac_valid && mac_op == MOP_EXEC) |-> !in_ready);

    // R12
    loc_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (loc_valid && !loc_ready) |-> !in_ready);

    // R12
    loc_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (loc_valid && !loc_ready && in_valid) |=> (loc_valid && $stable(loc_data) && $stable(loc_offset)));

    // R13
    reset_idle_chk: assert property (@(posedge clk)
        $past(rst) |-> !mac_valid || mac_op != MOP_EXEC);
endmodule

bind pb_method_decoder pbd_decoder_chk #(.N_ENG(N_ENG)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .loc_valid  (loc_valid),
    .loc_ready  (loc_ready),
    .loc_offset (loc_offset),
    .loc_data   (loc_data),
    .eng_valid  (eng_valid),
    .eng_ready  (eng_ready),
    .eng_offset (eng_offset),
    .mac_valid  (mac_valid),
    .mac_ready  (mac_ready),
    .mac_op     (mac_op),
    .mac_index  (mac_index),
    .mac_last   (mac_last)
);

// File: tb/pb_method_decoder_tb.sv
module pb_method_decoder_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic        in_ready;
    logic [31:0] in_word;
    logic        loc_valid, loc_ready, loc_last;
    logic [13:0] loc_offset;
    logic [31:0] loc_data;
    logic [4:0]  eng_valid, eng_ready;
    logic [13:0] eng_offset;
    logic [31:0] eng_data;
    logic        eng_last;
    logic        mac_valid, mac_ready, mac_last;
    logic [1:0]  mac_op;
    logic [6:0]  mac_index;
    logic [31:0] mac_data;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    pb_method_decoder dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_word(in_word),
        .loc_valid(loc_valid), .loc_ready(loc_ready), .loc_offset(loc_offset),
        .loc_data(loc_data), .loc_last(loc_last),
        .eng_valid(eng_valid), .eng_ready(eng_ready), .eng_offset(eng_offset),
        .eng_data(eng_data), .eng_last(eng_last),
        .mac_valid(mac_valid), .mac_ready(mac_ready), .mac_op(mac_op),
        .mac_index(mac_index), .mac_data(mac_data), .mac_last(mac_last)
    );

    // code: 0 none, 1 local, 2 engine, 3 macro start, 4 macro push, 5 macro execute
    typedef struct packed {
        logic [31:0] word;
        logic        vld;
        logic [2:0]  code;
        logic [13:0] addr;
        logic [2:0]  sub;
        logic [31:0] data;
        logic        last;
        logic        rdy;
    } vec_t;

    localparam int NV = 29;
    localparam vec_t VEC [0:NV-1] = '{
        '{32'h2003_0010, 1'b1, 3'd0, 14'h000, 3'd0, 32'h0,    1'b0, 1'b1}, // R1 R2 inc header
        '{32'h0000_00A0, 1'b1, 3'd1, 14'h040, 3'd0, 32'hA0,   1'b0, 1'b1}, // R3
        '{32'h0000_00A1, 1'b1, 3'd1, 14'h044, 3'd0, 32'hA1,   1'b0, 1'b1}, // R3
        '{32'h0000_00A2, 1'b1, 3'd1, 14'h048, 3'd0, 32'hA2,   1'b1, 1'b1}, // R3 R9
        '{32'h6002_4100, 1'b1, 3'd0, 14'h000, 3'd0, 32'h0,    1'b0, 1'b1}, // R4 header
        '{32'h0000_00B0, 1'b1, 3'd2, 14'h400, 3'd2, 32'hB0,   1'b0, 1'b1}, // R4
        '{32'h0000_00B1, 1'b1, 3'd2, 14'h400, 3'd2, 32'hB1,   1'b1, 1'b1}, // R4
        '{32'hA003_8200, 1'b1, 3'd0, 14'h000, 3'd0, 32'h0,    1'b0, 1'b1}, // R5 header
        '{32'h0000_00C0, 1'b1, 3'd2, 14'h800, 3'd4, 32'hC0,   1'b0, 1'b1}, // R5
        '{32'h0000_00C1, 1'b1, 3'd2, 14'h804, 3'd4, 32'hC1,   1'b0, 1'b1}, // R5
        '{32'h0000_00C2, 1'b1, 3'd2, 14'h804, 3'd4, 32'hC2,   1'b1, 1'b1}, // R5
        '{32'h9ABC_2080, 1'b1, 3'd2, 14'h200, 3'd1, 32'h1ABC, 1'b1, 1'b1}, // R2 immediate
        '{32'h0005_0123, 1'b1, 3'd0, 14'h000, 3'd0, 32'h0,    1'b0, 1'b1}, // R1 op0
        '{32'hE003_0010, 1'b1, 3'd0, 14'h000, 3'd0, 32'h0,    1'b0, 1'b1}, // R1 op7
        '{32'h4001_0010, 1'b1, 3'd0, 14'h000, 3'd0, 32'h0,    1'b0, 1'b1}, // R1 op2
        '{32'hC001_0010, 1'b1, 3'd0, 14'h000, 3'd0, 32'h0,    1'b0, 1'b1}, // R1 op6
        '{32'h2000_0010, 1'b1, 3'd0, 14'h000, 3'd0, 32'h0,    1'b0, 1'b1}, // R11 zero count
        '{32'h8001_0011, 1'b1, 3'd1, 14'h044, 3'd0, 32'h1,    1'b1, 1'b1}, // R11 next is header
        '{32'h2002_6E05, 1'b1, 3'd0, 14'h000, 3'd0, 32'h0,    1'b0, 1'b1}, // R8 macro header
        '{32'h0000_00D0, 1'b1, 3'd4, 14'h002, 3'd0, 32'hD0,   1'b0, 1'b1}, // R8 push
        '{32'h0000_00D1, 1'b1, 3'd3, 14'h003, 3'd0, 32'hD1,   1'b1, 1'b1}, // R8 start
        '{32'h0000_0000, 1'b0, 3'd5, 14'h003, 3'd0, 32'h0,    1'b1, 1'b0}, // R10 execute
        '{32'h8007_A100, 1'b1, 3'd0, 14'h000, 3'd0, 32'h0,    1'b0, 1'b1}, // R7 subch 5 dropped
        '{32'h8009_2E00, 1'b1, 3'd0, 14'h000, 3'd0, 32'h0,    1'b0, 1'b1}, // R8 subch 1 dropped
        '{32'h8055_0E10, 1'b1, 3'd3, 14'h008, 3'd0, 32'h55,   1'b1, 1'b1}, // R8 R9 immediate start
        '{32'h0000_0000, 1'b0, 3'd5, 14'h008, 3'd0, 32'h0,    1'b1, 1'b0}, // R10 execute
        '{32'h8003_E05F, 1'b1, 3'd1, 14'h17C, 3'd0, 32'h3,    1'b1, 1'b1}, // R6 subch 7
        '{32'h8002_0DFF, 1'b1, 3'd2, 14'h37FC,3'd0, 32'h2,    1'b1, 1'b1}, // R7 upper edge
        '{32'h8004_6060, 1'b1, 3'd2, 14'h180, 3'd3, 32'h4,    1'b1, 1'b1}  // R7 lower edge
    };

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [2:0] act_code();
        if (loc_valid)       return 3'd1;
        if (eng_valid != 0)  return 3'd2;
        if (mac_valid)       return 3'd3 + {1'b0, mac_op};
        return 3'd0;
    endfunction

    function automatic logic [2:0] eng_sub();
        for (int k = 0; k < 5; k++) if (eng_valid[k]) return 3'(k);
        return 3'd0;
    endfunction

    task automatic check_vec(input vec_t v, input string tag);
        logic [2:0]  c;
        logic [13:0] a;
        logic [31:0] d;
        logic        l;
        c = act_code();
        a = (c == 1) ? loc_offset : (c == 2) ? eng_offset : 14'(mac_index);
        d = (c == 1) ? loc_data   : (c == 2) ? eng_data   : mac_data;
        l = (c == 1) ? loc_last   : (c == 2) ? eng_last   : mac_last;
        check(in_ready == v.rdy, {tag, " ready"}, 64'(in_ready), 64'(v.rdy));
        check(c == v.code, {tag, " dest"}, 64'(c), 64'(v.code));
        if (v.code != 0 && c == v.code) begin
            check({a, d, l} == {v.addr, v.data, v.last}, {tag, " fields"},
                  64'({a, d, l}), 64'({v.addr, v.data, v.last}));
            if (c == 2) check(eng_sub() == v.sub, {tag, " subch"}, 64'(eng_sub()), 64'(v.sub));
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #(8 * 20000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        rst = 1'b1; in_valid = 1'b0; in_word = '0;
        loc_ready = 1'b1; eng_ready = '1; mac_ready = 1'b1;
        step(); step();
        rst = 1'b0;
        #2;
        // R13 reset state
        check(!loc_valid && eng_valid == 0 && !mac_valid && in_ready, "R13 idle",
              64'({loc_valid, eng_valid, mac_valid, in_ready}), 64'h1);
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            in_word  = VEC[i].word;
            in_valid = VEC[i].vld;
            #2;
            check_vec(VEC[i], $sformatf("R1-vector %0d (R%0d)", i, 1));
            step();
        end
        in_valid = 1'b0;

        // R13: reset mid burst clears it
        in_word = 32'h2003_0010; in_valid = 1'b1; step();
        in_word = 32'h0000_0077; step();
        in_valid = 1'b0; rst = 1'b1; step(); rst = 1'b0;
        in_word = 32'h0000_0000; in_valid = 1'b1; #2;
        check(act_code() == 0, "R13 burst cleared", 64'(act_code()), 64'h0);
        step(); in_valid = 1'b0;

        // R12: local back-pressure holds the write
        loc_ready = 1'b0;
        in_word = 32'h8033_0010; in_valid = 1'b1; #2;
        check(loc_valid && !in_ready, "R12 loc stall", 64'({loc_valid, in_ready}), 64'h2);
        step(); #2;
        check(loc_valid && loc_data == 32'h33 && !in_ready, "R12 loc held",
              64'(loc_data), 64'h33);
        loc_ready = 1'b1; #1;
        check(in_ready, "R12 loc release", 64'(in_ready), 64'h1);
        @(negedge clk); step(); in_valid = 1'b0;

        // R12: only the selected engine's ready matters
        eng_ready = 5'b11011;
        in_word = 32'h8009_4100; in_valid = 1'b1; #2;
        check(eng_valid == 5'b00100 && !in_ready, "R12 eng stall",
              64'({eng_valid, in_ready}), 64'({5'b00100, 1'b0}));
        eng_ready = 5'b00100; #1;
        check(in_ready, "R12 eng release", 64'(in_ready), 64'h1);
        @(negedge clk); step(); in_valid = 1'b0; eng_ready = '1;

        // R10: execute and a queued word in the same cycle
        in_word = 32'h8011_6E02; in_valid = 1'b1; #2;
        check(mac_valid && mac_op == 2'd0 && mac_index == 7'd1 && in_ready, "R10 start",
              64'({mac_op, mac_index}), 64'({2'd0, 7'd1}));
        step();
        in_word = 32'h8001_0010; #2;
        check(mac_valid && mac_op == 2'd2 && mac_index == 7'd1 && !in_ready && !loc_valid,
              "R10 exec first", 64'({mac_op, mac_index, in_ready, loc_valid}),
              64'({2'd2, 7'd1, 1'b0, 1'b0}));
        mac_ready = 1'b0;
        step(); #2;
        check(mac_valid && mac_op == 2'd2 && !in_ready, "R10 exec held",
              64'({mac_op, in_ready}), 64'({2'd2, 1'b0}));
        mac_ready = 1'b1;
        step(); #2;
        check(loc_valid && loc_offset == 14'h040 && loc_data == 32'h1 && in_ready,
              "R10 queued word after exec", 64'({loc_offset, loc_data}), 64'({14'h040, 32'h1}));
        step(); in_valid = 1'b0; #2;
        check(!mac_valid && !loc_valid, "R10 quiet", 64'({mac_valid, loc_valid}), 64'h0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule